// File: doc/BRIEF.md
# USB Controller Interrupt Aggregator with End-of-Interrupt Gate

This block sits next to a USB on-the-go controller core and gathers every interrupt-worthy event of that core into one 32-bit pending word. The events are pulses for each transmit endpoint, pulses for each receive endpoint, eight general core events, and a change on the VBUS-drive level. The CPU sees one level-sensitive interrupt line. It reads the pending word through a small word-addressed register bus, and it can view the pending word with or without the enable mask applied. Pending bits and enable bits never take a plain write. Each has a write-one-to-set port and a write-one-to-clear port, so software can acknowledge a subset of events, or force any event, without a read-modify-write race against the hardware.

Once the line has been raised, it stays closed to new assertions until software writes anything to the end-of-interrupt register. A service routine therefore reads the masked view, acknowledges what it handled, and ends with the end-of-interrupt write to re-arm the line. A self-clearing soft-reset bit returns the pending word, the mask and the gate to their power-on state. A read-only identification register always returns a fixed nonzero value.

Top module: `usb_irq_hub`

## Requirements
- R1: After reset the pending word (0x20), the mask (0x2C) and the control register (0x04) read zero, the interrupt line is low, and offset 0x00 reads the constant 0x4E310201.
- R2: A pulse on transmit event i (0..4) sets pending bit i. A pulse on receive event k-1 (endpoint k = 1..4) sets bit 8+k. A pulse on core event j (0..7) sets bit 16+j. Either edge of the VBUS-drive input sets bit 24. All other pending bits read zero and cannot be set.
- R3: Writing to 0x24 sets every pending bit written as 1. Writing to 0x28 clears every pending bit written as 1. Bits written as 0 keep their value.
- R4: A hardware event pulse that arrives in the same cycle as a 0x28 write clearing that bit leaves the bit set.
- R5: The mask changes only through 0x30 (ones set bits) and 0x34 (ones clear bits), using the same implemented bit positions as R2. Writes to 0x20 and 0x2C change nothing.
- R6: Offset 0x38 reads pending AND mask. When the gate is armed, the line rises one cycle after that value becomes nonzero. Unmasked pending bits never raise it.
- R7: The rising of the line disarms the gate. The line falls one cycle after the masked value becomes zero. It does not rise again until a write of any data to 0x3C re-arms the gate.
- R8: Bit 0 of offset 0x08 reads the present level of the VBUS-drive input.
- R9: Writing 1 to bit 0 of 0x04 makes that bit read 1 for one cycle. On the following edge the pending word and the mask clear, the line drops and the gate re-arms. Writing 0 has no effect.
- R10: Offsets other than those listed read zero, and writes to them change nothing. The write-only offsets 0x24, 0x28, 0x30, 0x34 and 0x3C read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte offset of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, combinational during a read access, else zero |
| tx_evt | input | NUM_TX (5) | Transmit endpoint event pulses |
| rx_evt | input | NUM_RX (4) | Receive endpoint event pulses, endpoint k on bit k-1 |
| core_evt | input | NUM_CORE (8) | General core event pulses |
| vbus_drv | input | 1 | Present VBUS-drive level |
| irq_o | output | 1 | Level interrupt to the CPU |

## Verification
Two situations are hard to reach from the ports. The first is the same-cycle race between a hardware pulse and a software acknowledge of the same bit. The bench reaches it by holding the event pulse and the 0x28 write in the same clock cycle, with a second bit in the same acknowledge word that must clear. The second is a new event after the line has fired but before end-of-interrupt. The bench reaches it by acknowledging the first event, raising a fresh masked event, holding for several idle cycles with the line low, and only then writing 0x3C. Full sweeps over all 32 bit positions of the set, clear and mask ports, and over all 64 word offsets, compare each result with a mask computed arithmetically from the field layout.

// File: rtl/usb_irq_hub_pkg.sv
package usb_irq_hub_pkg;

   // Register byte offsets (decoded by software, so they are fixed)
   localparam logic [31:0] OFS_IDENT    = 32'h00;
   localparam logic [31:0] OFS_CTRL     = 32'h04;
   localparam logic [31:0] OFS_LEVEL    = 32'h08;
   localparam logic [31:0] OFS_PEND     = 32'h20;
   localparam logic [31:0] OFS_PEND_SET = 32'h24;
   localparam logic [31:0] OFS_PEND_CLR = 32'h28;
   localparam logic [31:0] OFS_ENA      = 32'h2C;
   localparam logic [31:0] OFS_ENA_SET  = 32'h30;
   localparam logic [31:0] OFS_ENA_CLR  = 32'h34;
   localparam logic [31:0] OFS_ACTIVE   = 32'h38;
   localparam logic [31:0] OFS_EOI      = 32'h3C;

   typedef struct packed {
      logic pend_set;
      logic pend_clr;
      logic ena_set;
      logic ena_clr;
      logic eoi;
      logic ctrl;
   } wr_strobe_t;

endpackage

// File: rtl/usb_irq_hub_regif.sv
module usb_irq_hub_regif
   import usb_irq_hub_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 32,
   parameter logic [31:0] REVISION = 32'h4E31_0201
) (
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              ctrl_bit,
   input  logic              vbus_lvl,
   input  logic [DATA_W-1:0] pend_q,
   input  logic [DATA_W-1:0] ena_q,
   input  logic [DATA_W-1:0] active,
   output wr_strobe_t        wr,
   output logic [DATA_W-1:0] rdata
);

   logic [31:0] a32;
   logic        wr_acc;
   logic        rd_acc;

   assign a32    = 32'(bus_addr);
   assign wr_acc = bus_sel && bus_we;
   assign rd_acc = bus_sel && !bus_we;

   always_comb begin
      wr          = '0;
      wr.pend_set = wr_acc && (a32 == OFS_PEND_SET);
      wr.pend_clr = wr_acc && (a32 == OFS_PEND_CLR);
      wr.ena_set  = wr_acc && (a32 == OFS_ENA_SET);
      wr.ena_clr  = wr_acc && (a32 == OFS_ENA_CLR);
      wr.eoi      = wr_acc && (a32 == OFS_EOI);
      wr.ctrl     = wr_acc && (a32 == OFS_CTRL);
   end

   always_comb begin
      rdata = '0;
      if (rd_acc) begin
         case (a32)
            OFS_IDENT:  rdata = DATA_W'(REVISION);
            OFS_CTRL:   rdata = DATA_W'(ctrl_bit);
            OFS_LEVEL:  rdata = DATA_W'(vbus_lvl);
            OFS_PEND:   rdata = pend_q;
            OFS_ENA:    rdata = ena_q;
            OFS_ACTIVE: rdata = active;
            default:    rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/usb_irq_hub_w1bank.sv
module usb_irq_hub_w1bank #(
   parameter int unsigned   W    = 32,
   parameter logic [W-1:0]  IMPL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         srst,
   input  logic         set_we,
   input  logic         clr_we,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] hw_set,
   output logic [W-1:0] q
);

   logic [W-1:0] clr_bits;
   logic [W-1:0] set_bits;
   logic [W-1:0] nxt;

   assign clr_bits = clr_we ? wdata : '0;
   assign set_bits = set_we ? wdata : '0;
   // hardware and software setting are applied after clearing, so sets win
   assign nxt      = ((q & ~clr_bits) | set_bits | hw_set) & IMPL;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (srst)  q <= '0;
      else            q <= nxt;
   end

endmodule

// File: rtl/usb_irq_hub_gate.sv
module usb_irq_hub_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic srst,
   input  logic eoi_we,
   input  logic pending,
   output logic armed,
   output logic irq
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b1;
         irq   <= 1'b0;
      end else if (srst) begin
         armed <= 1'b1;
         irq   <= 1'b0;
      end else if (armed && pending) begin
         irq   <= 1'b1;
         armed <= 1'b0;
      end else begin
         if (!pending) irq   <= 1'b0;
         if (eoi_we)   armed <= 1'b1;
      end
   end

endmodule

// File: rtl/usb_irq_hub.sv
module usb_irq_hub
   import usb_irq_hub_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned NUM_TX    = 5,
   parameter int unsigned NUM_RX    = 4,
   parameter int unsigned NUM_CORE  = 8,
   parameter int unsigned RX_BASE   = 8,
   parameter int unsigned CORE_BASE = 16,
   parameter logic [31:0] REVISION  = 32'h4E31_0201
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_sel,
   input  logic                bus_we,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic [NUM_TX-1:0]   tx_evt,
   input  logic [NUM_RX-1:0]   rx_evt,
   input  logic [NUM_CORE-1:0] core_evt,
   input  logic                vbus_drv,
   output logic                irq_o
);

   // receive endpoints are numbered from 1, so endpoint k lands on RX_BASE+k
   localparam int unsigned RX_LO    = RX_BASE + 1;
   localparam int unsigned VBUS_BIT = CORE_BASE + NUM_CORE;

   function automatic logic [DATA_W-1:0] impl_bits();
      logic [DATA_W-1:0] m;
      m = '0;
      for (int i = 0; i < int'(NUM_TX); i++)   m[i]             = 1'b1;
      for (int i = 0; i < int'(NUM_RX); i++)   m[RX_LO + i]     = 1'b1;
      for (int i = 0; i < int'(NUM_CORE); i++) m[CORE_BASE + i] = 1'b1;
      m[VBUS_BIT] = 1'b1;
      return m;
   endfunction

   localparam logic [DATA_W-1:0] IMPL = impl_bits();

   initial begin
      assert (DATA_W == 32) else $error("DATA_W must be 32");
      assert (ADDR_W >= 6 && ADDR_W <= 16) else $error("ADDR_W out of range");
      assert (NUM_TX >= 1 && NUM_TX <= RX_LO) else $error("transmit field overlaps receive field");
      assert (NUM_RX >= 1 && RX_LO + NUM_RX <= CORE_BASE) else $error("receive field overlaps core field");
      assert (NUM_CORE >= 1 && VBUS_BIT < DATA_W) else $error("core field exceeds word");
      assert (REVISION != 32'h0) else $error("identification value must be nonzero");
   end

   wr_strobe_t        wr;
   logic              srst_q;
   logic              vbus_q;
   logic              vbus_chg;
   logic [DATA_W-1:0] evt_vec;
   logic [DATA_W-1:0] pend_q;
   logic [DATA_W-1:0] ena_q;
   logic [DATA_W-1:0] active;
   logic              pending;
   logic              armed;
   logic              ena_touch;

   // one-cycle soft reset request, self-clearing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) srst_q <= 1'b0;
      else        srst_q <= wr.ctrl && bus_wdata[0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vbus_q <= 1'b0;
      else        vbus_q <= vbus_drv;
   end

   assign vbus_chg = vbus_drv ^ vbus_q;

   // pack the event inputs into their field positions
   always_comb begin
      evt_vec = '0;
      evt_vec[VBUS_BIT] = vbus_chg;
   end

   logic [DATA_W-1:0] tx_vec;
   logic [DATA_W-1:0] rx_vec;
   logic [DATA_W-1:0] core_vec;

   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_pack
         if (i < NUM_TX) begin : g_tx
            assign tx_vec[i] = tx_evt[i];
         end else begin : g_tx_nc
            assign tx_vec[i] = 1'b0;
         end
         if (i >= RX_LO && i < RX_LO + NUM_RX) begin : g_rx
            assign rx_vec[i] = rx_evt[i - RX_LO];
         end else begin : g_rx_nc
            assign rx_vec[i] = 1'b0;
         end
         if (i >= CORE_BASE && i < VBUS_BIT) begin : g_core
            assign core_vec[i] = core_evt[i - CORE_BASE];
         end else begin : g_core_nc
            assign core_vec[i] = 1'b0;
         end
      end
   endgenerate

   logic [DATA_W-1:0] hw_set;
   assign hw_set = evt_vec | tx_vec | rx_vec | core_vec;

   usb_irq_hub_regif #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .REVISION(REVISION)
   ) u_regif (
      .bus_sel (bus_sel),
      .bus_we  (bus_we),
      .bus_addr(bus_addr),
      .ctrl_bit(srst_q),
      .vbus_lvl(vbus_drv),
      .pend_q  (pend_q),
      .ena_q   (ena_q),
      .active  (active),
      .wr      (wr),
      .rdata   (bus_rdata)
   );

   usb_irq_hub_w1bank #(.W(DATA_W), .IMPL(IMPL)) u_pend (
      .clk   (clk),
      .rst_n (rst_n),
      .srst  (srst_q),
      .set_we(wr.pend_set),
      .clr_we(wr.pend_clr),
      .wdata (bus_wdata),
      .hw_set(hw_set),
      .q     (pend_q)
   );

   usb_irq_hub_w1bank #(.W(DATA_W), .IMPL(IMPL)) u_ena (
      .clk   (clk),
      .rst_n (rst_n),
      .srst  (srst_q),
      .set_we(wr.ena_set),
      .clr_we(wr.ena_clr),
      .wdata (bus_wdata),
      .hw_set({DATA_W{1'b0}}),
      .q     (ena_q)
   );

   assign active    = pend_q & ena_q;
   assign pending   = |active;
   assign ena_touch = wr.ena_set || wr.ena_clr;

   usb_irq_hub_gate u_gate (
      .clk    (clk),
      .rst_n  (rst_n),
      .srst   (srst_q),
      .eoi_we (wr.eoi),
      .pending(pending),
      .armed  (armed),
      .irq    (irq_o)
   );

endmodule

// File: rtl/usb_irq_hub_chk.sv
module usb_irq_hub_chk #(
   parameter int unsigned W = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic [W-1:0] pend_q,
   input logic [W-1:0] ena_q,
   input logic [W-1:0] hw_set,
   input logic         srst_q,
   input logic         ena_touch,
   input logic         armed,
   input logic         pending,
   input logic         irq_o
);

   // R6: a rising line needs an armed gate and a masked pending bit
   assert_irq_needs_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> ($past(armed) && $past(pending)));

   // R7: no new assertion while the gate is closed
   assert_no_refire_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |=> !$rose(irq_o));

   // R9: soft reset returns pending, mask and line to idle
   assert_srst_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      srst_q |=> (pend_q == '0 && ena_q == '0 && !irq_o && armed));

   // R4: a hardware pulse always lands, even against a clear
   assert_event_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((|hw_set) && !srst_q) |=> ((pend_q & $past(hw_set)) == $past(hw_set)));

   // R5: mask holds unless its set or clear port is written
   assert_mask_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ena_touch && !srst_q) |=> $stable(ena_q));

endmodule

bind usb_irq_hub usb_irq_hub_chk #(.W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .pend_q   (pend_q),
   .ena_q    (ena_q),
   .hw_set   (hw_set),
   .srst_q   (srst_q),
   .ena_touch(ena_touch),
   .armed    (armed),
   .pending  (pending),
   .irq_o    (irq_o)
);

// File: tb/usb_irq_hub_test.sv
module usb_irq_hub_test;

   localparam logic [31:0] IMPL = 32'h0000_001F | (32'h1E << 8) | (32'h1FF << 16);

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [4:0]  tx_evt = '0;
   logic [3:0]  rx_evt = '0;
   logic [7:0]  core_evt = '0;
   logic        vbus_drv = 1'b0;
   logic        irq_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #5 clk = ~clk;

   usb_irq_hub uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tx_evt(tx_evt), .rx_evt(rx_evt), .core_evt(core_evt),
      .vbus_drv(vbus_drv), .irq_o(irq_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic softreset();
      wr(8'h04, 32'h1);
      idle(1);
   endtask

   logic [31:0] v;

   initial begin
      idle(2);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      rd(8'h20, v); chk("R1 pending after reset", v, 32'h0);
      rd(8'h2C, v); chk("R1 mask after reset", v, 32'h0);
      rd(8'h04, v); chk("R1 control after reset", v, 32'h0);
      rd(8'h00, v); chk("R1 identification", v, 32'h4E31_0201);
      chk("R1 line after reset", 32'(irq_o), 32'h0);

      // R3 set/clear sweep over all bit positions
      for (int b = 0; b < 32; b++) begin
         wr(8'h24, 32'h1 << b);
         rd(8'h20, v); chk($sformatf("R3 set bit %0d", b), v, (32'h1 << b) & IMPL);
         wr(8'h28, 32'h1 << b);
         rd(8'h20, v); chk($sformatf("R3 clear bit %0d", b), v, 32'h0);
      end
      wr(8'h24, 32'hFFFF_FFFF);
      wr(8'h28, 32'h0000_1E00);
      rd(8'h20, v); chk("R3 partial clear keeps zeros", v, IMPL & ~32'h1E00);
      wr(8'h28, 32'hFFFF_FFFF);

      // R2 event field placement
      for (int i = 0; i < 5; i++) begin
         @(negedge clk); tx_evt[i] = 1'b1; @(negedge clk); tx_evt = '0;
         rd(8'h20, v); chk($sformatf("R2 transmit %0d", i), v, 32'h1 << i);
         wr(8'h28, 32'hFFFF_FFFF);
      end
      for (int k = 1; k <= 4; k++) begin
         @(negedge clk); rx_evt[k-1] = 1'b1; @(negedge clk); rx_evt = '0;
         rd(8'h20, v); chk($sformatf("R2 receive ep %0d", k), v, 32'h1 << (8 + k));
         wr(8'h28, 32'hFFFF_FFFF);
      end
      for (int j = 0; j < 8; j++) begin
         @(negedge clk); core_evt[j] = 1'b1; @(negedge clk); core_evt = '0;
         rd(8'h20, v); chk($sformatf("R2 core %0d", j), v, 32'h1 << (16 + j));
         wr(8'h28, 32'hFFFF_FFFF);
      end

      // R2 / R8 VBUS-drive level and change
      @(negedge clk); vbus_drv = 1'b1; @(negedge clk);
      rd(8'h20, v); chk("R2 vbus rise sets bit 24", v, 32'h0100_0000);
      rd(8'h08, v); chk("R8 level high", v, 32'h1);
      wr(8'h28, 32'hFFFF_FFFF);
      idle(2);
      rd(8'h20, v); chk("R2 steady level no event", v, 32'h0);
      @(negedge clk); vbus_drv = 1'b0; @(negedge clk);
      rd(8'h20, v); chk("R2 vbus fall sets bit 24", v, 32'h0100_0000);
      rd(8'h08, v); chk("R8 level low", v, 32'h0);
      wr(8'h28, 32'hFFFF_FFFF);

      // R4 event against simultaneous clear
      wr(8'h24, 32'h8);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 8'h28; bus_wdata = 32'hC;
      tx_evt[2] = 1'b1;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0; tx_evt = '0;
      rd(8'h20, v); chk("R4 event beats clear", v, 32'h4);
      wr(8'h28, 32'hFFFF_FFFF);

      // R5 mask sweep and R6 masked view
      wr(8'h24, 32'hFFFF_FFFF);
      for (int b = 0; b < 32; b++) begin
         wr(8'h30, 32'h1 << b);
         rd(8'h2C, v); chk($sformatf("R5 mask set bit %0d", b), v, (32'h1 << b) & IMPL);
         rd(8'h38, v); chk($sformatf("R6 masked bit %0d", b), v, (32'h1 << b) & IMPL);
         wr(8'h34, 32'h1 << b);
         rd(8'h2C, v); chk($sformatf("R5 mask clear bit %0d", b), v, 32'h0);
      end
      wr(8'h2C, 32'hFFFF_FFFF);
      rd(8'h2C, v); chk("R5 direct mask write ignored", v, 32'h0);
      wr(8'h20, 32'h0);
      rd(8'h20, v); chk("R5 direct pending write ignored", v, IMPL);

      // R9 soft reset
      wr(8'h30, 32'h1);
      wr(8'h04, 32'h0);
      rd(8'h20, v); chk("R9 zero write no effect", v, IMPL);
      wr(8'h04, 32'h1);
      rd(8'h04, v); chk("R9 control reads one", v, 32'h1);
      idle(1);
      rd(8'h04, v); chk("R9 control self-clears", v, 32'h0);
      rd(8'h20, v); chk("R9 pending cleared", v, 32'h0);
      rd(8'h2C, v); chk("R9 mask cleared", v, 32'h0);
      chk("R9 line low", 32'(irq_o), 32'h0);

      // R6 / R7 interrupt gating
      wr(8'h30, 32'h1);
      wr(8'h24, 32'h2);
      idle(3);
      chk("R6 unmasked source no line", 32'(irq_o), 32'h0);
      @(negedge clk); tx_evt[0] = 1'b1; @(negedge clk); tx_evt = '0;
      chk("R6 line not yet high", 32'(irq_o), 32'h0);
      idle(1);
      chk("R6 line high", 32'(irq_o), 32'h1);
      wr(8'h28, 32'h1);
      chk("R7 line held until next edge", 32'(irq_o), 32'h1);
      idle(1);
      chk("R7 line falls after acknowledge", 32'(irq_o), 32'h0);
      @(negedge clk); tx_evt[0] = 1'b1; @(negedge clk); tx_evt = '0;
      idle(3);
      chk("R7 no refire without eoi", 32'(irq_o), 32'h0);
      rd(8'h38, v); chk("R7 masked pending while closed", v, 32'h1);
      wr(8'h3C, 32'h0);
      idle(1);
      chk("R7 refire after eoi", 32'(irq_o), 32'h1);
      softreset();
      wr(8'h30, 32'h1);
      wr(8'h24, 32'h1);
      idle(1);
      chk("R9 gate re-armed by soft reset", 32'(irq_o), 32'h1);

      // R10 unused and write-only offsets
      wr(8'h24, 32'hFFFF_FFFF);
      for (int w = 0; w < 64; w++) begin
         logic [7:0] a;
         a = 8'(w * 4);
         if (a inside {8'h24, 8'h28, 8'h30, 8'h34, 8'h3C}) begin
            rd(a, v); chk($sformatf("R10 write-only %h reads zero", a), v, 32'h0);
         end else if (!(a inside {8'h00, 8'h04, 8'h08, 8'h20, 8'h2C, 8'h38})) begin
            wr(a, 32'hFFFF_FFFF);
            rd(a, v); chk($sformatf("R10 unused %h reads zero", a), v, 32'h0);
            rd(8'h20, v); chk($sformatf("R10 pending after write %h", a), v, IMPL);
            rd(8'h2C, v); chk($sformatf("R10 mask after write %h", a), v, 32'h1);
         end
      end
      rd(8'h41, v); chk("R10 misaligned reads zero", v, 32'h0);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule